// File: doc/BRIEF.md
# Two-Key Watchdog Timer

This block is a watchdog that raises a system reset request unless software services it in time. Servicing takes an ordered pair of byte writes to one service address. The first write, 0x55, arms the block. The second write, 0xAA, clears the timeout counter. Any number of other bus writes may fall between the two without cancelling the arm.

The timeout base comes from a free-running prescaler. It counts bus clock enables and overflows once every 2^PRE_BITS of them. Servicing never clears this prescaler. A two-bit rate code then sets how many base periods must pass before expiry. A disable input stops the watchdog. With that input low, the block runs from reset.

Top module: `wdog_twokey`

## Requirements
- R1: Under reset (rst_n low), rst_req is low and the prescaler, timeout counter and armed flag are zero. With no service after reset, the request rises after (L+1) base periods, counted from reset release.
- R2: A write of 0x55 to SVC_ADDR with wr_en high sets the armed flag. It does not change the timeout counter.
- R3: A write of 0xAA to SVC_ADDR while armed clears the timeout counter and drops the armed flag. Each service therefore needs a fresh 0x55/0xAA pair.
- R4: A write of 0xAA to SVC_ADDR while not armed has no effect.
- R5: The following leave the armed flag unchanged: a write of any other value to SVC_ADDR, a write to any other address, and any cycle with wr_en low.
- R6: A base tick occurs on each enabled cycle in which the prescaler (PRE_BITS wide, advancing on tick_en) wraps. Servicing does not reset the prescaler.
- R7: After a clear, rst_req rises on the base tick at which the counter already holds L. Here L is 1, 4, 16 or 64 for rate_sel 00, 01, 10 and 11. The time from clear to request therefore lies in (L, L+1] base periods.
- R8: rst_req is a registered pulse exactly one clock wide.
- R9: While wd_off is 1, the counter is held at zero and rst_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low system reset |
| tick_en | input | 1 | bus clock enable that drives the prescaler |
| wr_en | input | 1 | write strobe |
| wr_addr | input | ADDR_W | write address |
| wr_data | input | 8 | write data |
| wd_off | input | 1 | 1 disables the watchdog |
| rate_sel | input | 2 | timeout rate code |
| rst_req | output | 1 | one-cycle reset request pulse |

## Verification
The bench shrinks the prescaler to 8 cycles and sweeps all four rate codes. For each code it checks that expiry falls inside the (L, L+1] window. A design that miscounts by one base period would fire outside that window.

Services are placed at prescaler phases that are not aligned to a base tick, so the exact expiry cycle exposes any design that restarts the prescaler on a clear. Further cases cover an arm alone, a clear with no arm, a repeated clear, and noise writes between arm and clear; a wrong key sequence would fire late or early by a whole timeout. A disabled run then shows that no request escapes while wd_off is high.

// File: rtl/wdog_twokey.sv
module wdog_twokey #(
  parameter int PRE_BITS = 15,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h10,
  parameter logic [7:0] KEY_ARM = 8'h55,
  parameter logic [7:0] KEY_CLR = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wd_off,
  input  logic [1:0]        rate_sel,
  output logic              rst_req
);
  localparam int CNT_W = 7;

  logic [PRE_BITS-1:0] pre;
  logic [CNT_W-1:0]    cnt;
  logic                armed;

  wire svc_wr    = wr_en && (wr_addr == SVC_ADDR);
  wire arm_hit   = svc_wr && (wr_data == KEY_ARM);
  wire clr_hit   = svc_wr && (wr_data == KEY_CLR) && armed;
  wire base_tick = tick_en && (&pre);
  wire [CNT_W-1:0] limit = CNT_W'(1) << {rate_sel, 1'b0};
  wire expire    = !wd_off && base_tick && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      armed   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (tick_en) pre <= pre + 1'b1;
      rst_req <= expire;
      if (wd_off || clr_hit || expire) cnt <= '0;
      else if (base_tick) cnt <= cnt + 1'b1;
      if (clr_hit || expire) armed <= 1'b0;
      else if (arm_hit) armed <= 1'b1;
    end
  end

  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_hit && !expire) |=> armed);
  p_arm_keeps_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_hit && !base_tick && !wd_off) |=> (cnt == $past(cnt)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt == '0 && !armed));
  p_noarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && wr_data == KEY_CLR && !armed && !base_tick && !wd_off) |=> (cnt == $past(cnt)));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> (!rst_req && cnt == '0));
endmodule

// File: tb/wdog_twokey_test.sv
module wdog_twokey_test;
  localparam int PB = 3;
  localparam int P = 1 << PB;
  localparam logic [7:0] SVC = 8'h10;

  logic clk = 0, rst_n = 0, tick_en = 1, wr_en = 0, wd_off = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [1:0] rate_sel = 0;
  logic rst_req;
  int cyc = 0, t0 = 0, checks = 0, errors = 0;
  bit seen_off = 0;

  wdog_twokey #(.PRE_BITS(PB), .SVC_ADDR(SVC)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wd_off(wd_off), .rate_sel(rate_sel), .rst_req(rst_req));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (wd_off && rst_req) seen_off = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] r, input logic off);
    @(negedge clk); rst_n = 0; rate_sel = r; wd_off = off;
    repeat (3) @(negedge clk);
    rst_n = 1; t0 = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic en);
    @(negedge clk); wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_to(input int m);
    while (cyc - t0 < m) @(negedge clk);
  endtask

  task automatic service(output int m);
    wr(SVC, 8'h55, 1); wr(SVC, 8'hAA, 1); m = cyc - t0;
  endtask

  task automatic wait_req(output int t);
    int n = 0;
    while (!rst_req && n < 3000) begin @(negedge clk); n++; end
    t = cyc - t0;
    @(negedge clk);
    chk(!rst_req, "R8 pulse width", rst_req, 0);
  endtask

  function automatic int exact(input int m, input int l);
    return P * (m / P + l + 1);
  endfunction

  initial begin
    int m, m2, t, l;
    @(negedge clk); @(negedge clk);
    chk(rst_req == 0, "R1 reset output", rst_req, 0);
    for (int r = 0; r < 4; r++) begin
      l = 1 << (2 * r);
      do_reset(r[1:0], 0);
      wait_req(t);
      chk(t == (l + 1) * P, "R1 expiry from reset", t, (l + 1) * P);
      do_reset(r[1:0], 0);
      wait_to(3);
      service(m);
      wait_req(t);
      chk(t - m > l * P && t - m <= (l + 1) * P, "R7 window", t - m, (l + 1) * P);
      chk(t == exact(m, l), "R6 prescaler free-running", t, exact(m, l));
    end
    l = 4;
    do_reset(2'b01, 0); wait_to(9); service(m);
    wait_to(m + 18); wr(SVC, 8'h55, 1);
    wait_req(t);
    chk(t == exact(m, l), "R2 arm alone no clear", t, exact(m, l));
    do_reset(2'b01, 0); wait_to(9); service(m);
    wait_to(m + 18); wr(SVC, 8'hAA, 1);
    wait_req(t);
    chk(t == exact(m, l), "R4 clear without arm", t, exact(m, l));
    do_reset(2'b01, 0); wait_to(9); service(m);
    wait_to(m + 12); wr(SVC, 8'hAA, 1);
    wait_req(t);
    chk(t == exact(m, l), "R3 armed dropped after clear", t, exact(m, l));
    do_reset(2'b01, 0); wait_to(9); service(m);
    wait_to(m + 12); wr(SVC, 8'h55, 1);
    wr(SVC, 8'h12, 1); wr(8'h11, 8'hAA, 1); wr(SVC, 8'hAA, 0); wr(8'h22, 8'h33, 1);
    wr(SVC, 8'hAA, 1); m2 = cyc - t0;
    wait_req(t);
    chk(t == exact(m2, l), "R5 noise keeps arm", t, exact(m2, l));
    do_reset(2'b01, 0); wait_to(10); service(m);
    wait_to(m + 14); wr(SVC, 8'h55, 1); wr(8'h11, 8'hAA, 1);
    wait_req(t);
    chk(t == exact(m, l), "R5 other address ignored", t, exact(m, l));
    do_reset(2'b11, 1);
    repeat (700) @(negedge clk);
    chk(!seen_off, "R9 no request when off", seen_off, 0);
    wd_off = 0; m = cyc - t0;
    wait_req(t);
    chk(t - m > 64 * P && t - m <= 65 * P + 1, "R9 counter held zero", t - m, 65 * P);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule